// File: doc/BRIEF.md
# FSK Deviation Selection Controller

This block produces the signed frequency-deviation word that offsets a synthesizer's fractional N-divider value during frequency-shift keying. It also produces the resulting divider value, which is the sum of a 24-bit base N value and the sign-extended deviation. Four sources can drive the deviation, and a mode field selects which one is live.

The first source is a symbol presented on three data pins and captured by a separate symbol clock. The second is a symbol index written through the configuration port. The third is an arbitrary deviation written directly through the configuration port. The fourth is a 16-bit word shifted in serially on the same three pins. A bank of eight deviation registers holds one preset per symbol value. The symbol-driven sources look up the deviation in that bank. The direct and serial sources bypass the bank, so any level can be produced. That allows pulse shaping or analog FM.

The pins are asynchronous to the system clock and are brought in through a two-flop synchronizer. The output deviation changes only when the selected source delivers a new value. Any write to the mode register clears it to zero.

Top module: `fsk_dev_ctrl`

## Requirements
- R1: After reset, and whenever `rst_n` is low, `dev_o` is 0 and `n_o` equals `base_n`. The mode register resets to 0, which means symbol-pin mode, 2-level operation and frame-sync polarity 0.
- R2: `n_o` always equals `base_n` plus `dev_o` read as a 16-bit two's-complement number, taken modulo 2^24.
- R3: A configuration write to addresses 0 to 7 stores `cfg_wdata` as the preset for that symbol value. In mode code 0 (symbol-pin mode), a rising edge on `sym_clk` latches `sym_pin` (bit 0 = D0). Within 4 system clocks, `dev_o` then shows the preset for the latched symbol, and it holds that value until the next rising edge.
- R4: Mode register bits [3:2] give the number of levels. Code 0 means 2-level, where only D0 is used. Code 1 means 4-level, where D0 and D1 are used. Codes 2 and 3 mean 8-level. Unused upper symbol bits are read as zero.
- R5: In mode code 1 (register-select mode), a write to address 9 makes `dev_o` equal to the preset indexed by `cfg_wdata[2:0]` on the next clock.
- R6: In mode code 2 (direct mode), a write to address 10 makes `dev_o` equal to `cfg_wdata` on the next clock.
- R7: In mode code 3 (serial mode), `sym_pin[0]` is the serial clock, `sym_pin[1]` the frame sync and `sym_pin[2]` the data. Data is sampled on rising serial-clock edges while the frame sync is at its active level, most significant bit first. Within 5 system clocks of the 16th bit, `dev_o` shows the received word.
- R8: Mode register bit 4 sets the active frame-sync level: 1 means high, 0 means low. Bits sent while the sync is at the other level are not received.
- R9: A write to address 8 loads the mode register from `cfg_wdata[4:0]`, with bits [1:0] as the mode code. On the next clock the new mode is in force and `dev_o` is 0.
- R10: Sources other than the one selected by the mode have no effect on `dev_o`. This covers direct writes outside direct mode, symbol-clock edges outside symbol-pin mode, and select writes outside register-select mode. Rewriting a preset does not change `dev_o` until the next selection event.
- R11: In serial mode, a frame with fewer than 16 bits is discarded. Bits after the 16th in the same frame are ignored. A serial-clock edge at the inactive sync level starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address: 0-7 presets, 8 mode, 9 select, 10 direct |
| cfg_wdata | input | 16 | Configuration write data |
| base_n | input | 24 | Base N-divider value |
| sym_clk | input | 1 | Asynchronous symbol clock for symbol-pin mode |
| sym_pin | input | 3 | Symbol pins D2..D0, which also carry the serial clock, sync and data |
| dev_o | output | 16 | Current two's-complement deviation |
| n_o | output | 24 | Base N value plus the sign-extended deviation |

## Verification
A corrupted preset bank or a wrong symbol mask appears on `dev_o` within 4 clocks of the symbol-clock edge that selects the entry. The error is therefore pinned to a specific symbol value. A broken serial bit counter shows up as a wrong or missing word about 5 clocks after a frame's 16th bit. Frames that are too short or too long test that counter from both sides. A deviation that is not cleared, or a source that leaks through in the wrong mode, is visible on the very next clock after the mode write or the ignored stimulus.

// File: rtl/fsk_dev_pkg.sv
package fsk_dev_pkg;
  localparam int DEV_W  = 16;
  localparam int N_W    = 24;
  localparam int SYM_W  = 3;
  localparam int ADDR_W = 4;
  localparam int NSYM   = 2 ** SYM_W;

  localparam logic [ADDR_W-1:0] ADDR_MODE = ADDR_W'(NSYM);
  localparam logic [ADDR_W-1:0] ADDR_SEL  = ADDR_W'(NSYM + 1);
  localparam logic [ADDR_W-1:0] ADDR_DIR  = ADDR_W'(NSYM + 2);

  typedef enum logic [1:0] {
    MODE_PIN    = 2'd0,
    MODE_REGSEL = 2'd1,
    MODE_DIRECT = 2'd2,
    MODE_SERIAL = 2'd3
  } fsk_mode_e;

  // keep only the symbol bits that the level setting uses
  function automatic logic [SYM_W-1:0] sym_mask(input logic [SYM_W-1:0] s,
                                                 input logic [1:0] lvl);
    case (lvl)
      2'd0:    return {2'b00, s[0]};
      2'd1:    return {1'b0, s[1:0]};
      default: return s;
    endcase
  endfunction

  // divider value: base plus sign-extended deviation, wrapping
  function automatic logic [N_W-1:0] n_sum(input logic [N_W-1:0] base,
                                            input logic [DEV_W-1:0] dev);
    return base + {{(N_W-DEV_W){dev[DEV_W-1]}}, dev};
  endfunction
endpackage

// File: rtl/fsk_sync_edge.sv
module fsk_sync_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-2:0] lvl_o,
  output logic         rise0_o
);
  logic [W-1:0] ff1_q, ff2_q;
  logic         prev0_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ff1_q   <= '0;
      ff2_q   <= '0;
      prev0_q <= 1'b0;
    end else begin
      ff1_q   <= async_i;
      ff2_q   <= ff1_q;
      prev0_q <= ff2_q[0];
    end
  end

  assign lvl_o   = ff2_q[W-1:1];
  assign rise0_o = ff2_q[0] & ~prev0_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise0_o |=> !rise0_o); // R3
endmodule

// File: rtl/fsk_serial_rx.sv
module fsk_serial_rx
  import fsk_dev_pkg::*;
#(
  parameter int W = DEV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         pol_i,
  input  logic         sclk_i,
  input  logic         fs_i,
  input  logic         sd_i,
  output logic         vld_o,
  output logic [W-1:0] word_o
);
  localparam int CNT_W = $clog2(W);

  logic             sclk_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [W-2:0]     sh_q;
  logic             sclk_rise, fs_active, last_bit;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign fs_active = (fs_i == pol_i);
  assign last_bit  = (cnt_q == CNT_W'(W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      sh_q   <= '0;
      vld_o  <= 1'b0;
      word_o <= '0;
    end else begin
      sclk_q <= sclk_i;
      vld_o  <= 1'b0;
      if (!en_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (sclk_rise) begin
        if (!fs_active) begin
          cnt_q  <= '0;
          done_q <= 1'b0;
        end else if (!done_q) begin
          if (last_bit) begin
            word_o <= {sh_q, sd_i};
            vld_o  <= 1'b1;
            done_q <= 1'b1;
            cnt_q  <= '0;
          end else begin
            sh_q  <= {sh_q[W-3:0], sd_i};
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  AST_WORD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o); // R7
  AST_IDLE_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0) && !vld_o); // R11
endmodule

// File: rtl/fsk_dev_regs.sv
module fsk_dev_regs
  import fsk_dev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DEV_W-1:0]  wdata_i,
  output logic [DEV_W-1:0]  tbl_o [NSYM],
  output fsk_mode_e         mode_o,
  output logic [1:0]        lvl_o,
  output logic              pol_o,
  output logic              mode_wr_o,
  output logic              sel_wr_o,
  output logic              dir_wr_o
);
  assign mode_wr_o = we_i && (addr_i == ADDR_MODE);
  assign sel_wr_o  = we_i && (addr_i == ADDR_SEL);
  assign dir_wr_o  = we_i && (addr_i == ADDR_DIR);

  for (genvar i = 0; i < NSYM; i++) begin : g_preset
    logic hit;
    assign hit = we_i && (addr_i == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   tbl_o[i] <= '0;
      else if (hit) tbl_o[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o <= MODE_PIN;
      lvl_o  <= 2'd0;
      pol_o  <= 1'b0;
    end else if (mode_wr_o) begin
      mode_o <= fsk_mode_e'(wdata_i[1:0]);
      lvl_o  <= wdata_i[3:2];
      pol_o  <= wdata_i[4];
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr_o |=> $stable(mode_o) && $stable(lvl_o) && $stable(pol_o)); // R9
endmodule

// File: rtl/fsk_dev_ctrl.sv
module fsk_dev_ctrl
  import fsk_dev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DEV_W-1:0]  cfg_wdata,
  input  logic [N_W-1:0]    base_n,
  input  logic              sym_clk,
  input  logic [SYM_W-1:0]  sym_pin,
  output logic [DEV_W-1:0]  dev_o,
  output logic [N_W-1:0]    n_o
);
  logic [DEV_W-1:0] tbl [NSYM];
  fsk_mode_e        mode;
  logic [1:0]       lvl;
  logic             pol, mode_wr, sel_wr, dir_wr;
  logic [SYM_W-1:0] pin_s, sym_idx;
  logic             sym_stb, ser_vld, upd_any;
  logic [DEV_W-1:0] ser_word, dev_q;

  fsk_dev_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .tbl_o(tbl), .mode_o(mode), .lvl_o(lvl),
    .pol_o(pol), .mode_wr_o(mode_wr), .sel_wr_o(sel_wr), .dir_wr_o(dir_wr)
  );

  fsk_sync_edge #(.W(SYM_W + 1)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({sym_pin, sym_clk}),
    .lvl_o(pin_s), .rise0_o(sym_stb)
  );

  fsk_serial_rx #(.W(DEV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(mode == MODE_SERIAL), .pol_i(pol),
    .sclk_i(pin_s[0]), .fs_i(pin_s[1]), .sd_i(pin_s[2]),
    .vld_o(ser_vld), .word_o(ser_word)
  );

  assign sym_idx = sym_mask(pin_s, lvl);
  assign upd_any = mode_wr | sym_stb | sel_wr | dir_wr | ser_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_q <= '0;
    end else if (mode_wr) begin
      dev_q <= '0;
    end else begin
      case (mode)
        MODE_PIN:    if (sym_stb) dev_q <= tbl[sym_idx];
        MODE_REGSEL: if (sel_wr)  dev_q <= tbl[cfg_wdata[SYM_W-1:0]];
        MODE_DIRECT: if (dir_wr)  dev_q <= cfg_wdata;
        MODE_SERIAL: if (ser_vld) dev_q <= ser_word;
        default: ;
      endcase
    end
  end

  assign dev_o = dev_q;
  assign n_o   = n_sum(base_n, dev_q);

  AST_MODE_CLEARS_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (dev_o == '0)); // R9
  AST_DEV_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_any |=> $stable(dev_o)); // R10
  AST_PIN_LEVEL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 2'd0) |-> (sym_idx[SYM_W-1:1] == '0)); // R4
endmodule

// File: tb/fsk_dev_ctrl_test.sv
`timescale 1ns/1ps
module fsk_dev_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [23:0] base_n = 24'h100000;
  logic        sym_clk = 1'b0;
  logic [2:0]  sym_pin = '0;
  logic [15:0] dev_o;
  logic [23:0] n_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fsk_dev_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .base_n(base_n), .sym_clk(sym_clk),
    .sym_pin(sym_pin), .dev_o(dev_o), .n_o(n_o)
  );

  // {deviation, base, expected divider}
  localparam logic [63:0] VEC [6] = '{
    64'h0010_100000_100010,
    64'hFFFF_100000_0FFFFF,
    64'h8000_100000_0F8000,
    64'h7FFF_100000_107FFF,
    64'hFFF0_000005_FFFFF5,
    64'h0002_FFFFFF_000001
  };

  function automatic logic [15:0] preset(input int i);
    return (i == 7) ? 16'hF800 : 16'(16'h0100 * (i + 1) + i);
  endfunction

  function automatic logic [23:0] exp_n(input logic [23:0] b, input logic [15:0] d);
    int s;
    s = int'(b) + int'($signed(d));
    return 24'(s);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pin_sym(input logic [2:0] s);
    sym_pin = s;
    repeat (3) @(negedge clk);
    sym_clk = 1'b1;
    repeat (6) @(negedge clk);
    sym_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sclk_tick();
    repeat (3) @(negedge clk);
    sym_pin[0] = 1'b1;
    repeat (3) @(negedge clk);
    sym_pin[0] = 1'b0;
  endtask

  task automatic ser_send(input logic [31:0] val, input int nbits, input bit pol);
    sym_pin[1] = ~pol;
    sclk_tick();
    sym_pin[1] = pol;
    for (int k = 0; k < nbits; k++) begin
      sym_pin[2] = val[nbits-1-k];
      sclk_tick();
    end
    repeat (2) @(negedge clk);
    sym_pin[1] = ~pol;
    sclk_tick();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (4) @(negedge clk);
    chk(32'(dev_o), 0, "R1 reset deviation");
    chk(32'(n_o), 32'h100000, "R1 reset divider");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) cfg_write(4'(i), preset(i));

    // 8-level symbol sweep
    cfg_write(4'd8, 16'h0008);
    for (int i = 0; i < 8; i++) begin
      pin_sym(3'(i));
      chk(32'(dev_o), 32'(preset(i)), "R3 symbol preset");
      chk(32'(n_o), 32'(exp_n(base_n, preset(i))), "R2 divider sum");
    end

    // 2-level: only D0
    cfg_write(4'd8, 16'h0000);
    chk(32'(dev_o), 0, "R9 mode write clears");
    pin_sym(3'b111);
    chk(32'(dev_o), 32'(preset(1)), "R4 2-level 111");
    pin_sym(3'b110);
    chk(32'(dev_o), 32'(preset(0)), "R4 2-level 110");
    // 4-level: D0,D1
    cfg_write(4'd8, 16'h0004);
    pin_sym(3'b111);
    chk(32'(dev_o), 32'(preset(3)), "R4 4-level 111");
    pin_sym(3'b110);
    chk(32'(dev_o), 32'(preset(2)), "R4 4-level 110");

    cfg_write(4'd10, 16'h5555);
    @(negedge clk);
    chk(32'(dev_o), 32'(preset(2)), "R10 direct write in pin mode");

    // direct mode vector table
    cfg_write(4'd8, 16'h0002);
    for (int v = 0; v < 6; v++) begin
      base_n = VEC[v][47:24];
      cfg_write(4'd10, VEC[v][63:48]);
      chk(32'(dev_o), 32'(VEC[v][63:48]), "R6 direct deviation");
      chk(32'(n_o), 32'(VEC[v][23:0]), "R2 vector divider");
    end
    base_n = 24'h200000;
    held = dev_o;
    pin_sym(3'b101);
    chk(32'(dev_o), 32'(held), "R10 symbol clock in direct mode");
    cfg_write(4'd8, 16'h0002);
    chk(32'(dev_o), 0, "R9 same-mode write clears");

    // register-select mode
    cfg_write(4'd8, 16'h0001);
    cfg_write(4'd9, 16'h0005);
    chk(32'(dev_o), 32'(preset(5)), "R5 select 5");
    cfg_write(4'd9, 16'h0007);
    chk(32'(dev_o), 32'(preset(7)), "R5 select 7");
    chk(32'(n_o), 32'(exp_n(24'h200000, preset(7))), "R2 negative preset");
    cfg_write(4'd3, 16'h0333);
    chk(32'(dev_o), 32'(preset(7)), "R10 preset rewrite holds output");
    cfg_write(4'd10, 16'h4444);
    chk(32'(dev_o), 32'(preset(7)), "R10 direct write in select mode");
    cfg_write(4'd9, 16'h0003);
    chk(32'(dev_o), 32'h0333, "R5 select rewritten preset");

    // serial mode, sync active high
    cfg_write(4'd8, 16'h0013);
    ser_send(32'hA5C3, 16, 1'b1);
    chk(32'(dev_o), 32'hA5C3, "R7 serial word");
    cfg_write(4'd9, 16'h0001);
    chk(32'(dev_o), 32'hA5C3, "R10 select write in serial mode");
    // active low
    cfg_write(4'd8, 16'h0003);
    ser_send(32'h1E0F, 16, 1'b0);
    chk(32'(dev_o), 32'h1E0F, "R8 active-low sync");
    ser_send(32'h7777, 16, 1'b1);
    chk(32'(dev_o), 32'h1E0F, "R8 wrong sync level ignored");
    ser_send(32'h02AB, 10, 1'b0);
    chk(32'(dev_o), 32'h1E0F, "R11 short frame discarded");
    ser_send(32'hABCDE, 20, 1'b0);
    chk(32'(dev_o), 32'hABCD, "R11 extra bits ignored");

    // reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(32'(dev_o), 0, "R1 reset clears deviation");
    chk(32'(n_o), 32'h200000, "R1 reset divider equals base");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule